// File: doc/BRIEF.md
# Oscillation-Settling Wait Timer

This block is an 8-bit up-counter with a selectable prescaler. It has two jobs. In normal operation it is a watchdog or interval timer. When its enable bit is set, a counter overflow produces either a reset pulse or an interrupt pulse, and it sets a sticky overflow flag.

Its second job is to hold the system clock off while an oscillator or PLL settles. Software first clears the enable bit, then loads a start value and picks a prescale ratio. It then issues one of two requests:

- **Frequency-change request.** The system clock is gated off at once and counting begins immediately.
- **Standby request.** The clock is gated off, and the counter waits for an edge on the synchronized NMI input before it starts.

When a settling count overflows, the block pulses a clock-resume output and releases the clock-stop level. It does not touch the overflow flag, and the counter stays at 0x00 so that software can read it back. A reset applied during standby returns the block to normal operation, and no settling count takes place.

Top module: `settle_wdt`

## Requirements
- R1: After reset, the control, count and flag registers all read 0, `clk_stop` is low and no pulse output is high. A reset taken while waiting in standby also leaves the counter idle; a later NMI edge does not start a count.
- R2: The control register is at address 0: bit 7 is enable, bit 6 is reset-mode, and bits 2:0 are the prescale select. Select values 0 to 7 divide by 1, 4, 16, 32, 64, 256, 1024 and 4096. When counting starts at a clock edge, an overflow from start value L occurs exactly (256-L)*ratio edges later.
- R3: With enable=1, reset-mode=0 and no settling in progress, an overflow gives a one-cycle `wdt_irq` pulse and sets the flag (address 2, bit 0). The counter wraps to 0 and keeps counting.
- R4: With enable=1 and reset-mode=1, an overflow gives a one-cycle `wdt_reset` pulse instead of `wdt_irq`, and it also sets the flag.
- R5: With enable=0 and no settling in progress, the counter (address 1) holds its value.
- R6: A `freq_req` pulse raises `clk_stop` at the next edge, and counting starts from that edge.
- R7: A settling overflow gives a one-cycle `clk_resume` pulse and drops `clk_stop` in the same cycle. It leaves the flag unchanged.
- R8: After a settling overflow, the counter reads 0x00 and stays there (enable=0) until software writes it.
- R9: After `standby_req`, `clk_stop` goes high and the counter holds until an NMI edge of the configured polarity is seen (`nmi_rise`=1 for rising, 0 for falling). Counting starts 3 edges after the input changes. An edge of the other polarity is ignored.
- R10: Writing 0 to flag bit 0 clears the flag only if a read of address 2 returned it as 1 beforehand. Without that read, the write leaves the flag set.
- R11: If a watchdog overflow and a flag-clearing write fall on the same edge, the flag stays set.
- R12: A write to the count register takes priority over a prescaler tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register address: 0 control, 1 count, 2 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| standby_req | input | 1 | Enter standby; counting waits for an NMI edge |
| freq_req | input | 1 | Frequency change; counting starts at once |
| nmi_in | input | 1 | Asynchronous NMI line |
| nmi_rise | input | 1 | NMI edge polarity: 1 rising, 0 falling |
| clk_stop | output | 1 | System clock gated off while high |
| clk_resume | output | 1 | One-cycle pulse at the end of a settling count |
| wdt_reset | output | 1 | One-cycle watchdog reset pulse |
| wdt_irq | output | 1 | One-cycle interval interrupt pulse |

## Verification
Two events can land on the same edge: a watchdog overflow that sets the flag, and a software write of 0 that clears an already-read flag. The bench arms the clear by reading the flag. It then enables counting from 0xF0 with divide-by-1 and places the clear write on exactly the sixteenth edge. The result is judged correct if the flag still reads 1 and `wdt_irq` is high in that same cycle. A second, untimed case checks that the same clear works when nothing collides with it.

// File: rtl/swt_pkg.sv
// Package: shared register addresses, control state and prescale decode
// for the settling wait timer. Assumes a 2-bit register address space.
package swt_pkg;

    typedef enum logic [1:0] {
        SWT_A_CTRL  = 2'd0,
        SWT_A_COUNT = 2'd1,
        SWT_A_STAT  = 2'd2
    } swt_addr_e;

    typedef enum logic [1:0] {
        SWT_RUN       = 2'd0,
        SWT_WAIT_EDGE = 2'd1,
        SWT_SETTLE    = 2'd2
    } swt_state_e;

    // Returns log2 of the divide ratio chosen by a select code.
    function automatic logic [3:0] swt_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    swt_shift = 4'd0;
            3'd1:    swt_shift = 4'd2;
            3'd2:    swt_shift = 4'd4;
            3'd3:    swt_shift = 4'd5;
            3'd4:    swt_shift = 4'd6;
            3'd5:    swt_shift = 4'd8;
            3'd6:    swt_shift = 4'd10;
            default: swt_shift = 4'd12;
        endcase
    endfunction

endpackage

// File: rtl/swt_prescale.sv
// Prescaler: emits one tick every 2**shift cycles while 'active' is high.
// It restarts from zero whenever 'active' is low, so the latency from start
// to the first tick is exactly one full period. Assumes PRE_W >= 12.
module swt_prescale #(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [2:0] sel,
    output logic       tick
);
    import swt_pkg::*;

    localparam int CMP_W = PRE_W + 1;

    logic [PRE_W-1:0] pre;
    logic [CMP_W-1:0] ratio_m1;

    // Terminal count for the selected ratio.
    assign ratio_m1 = ({{PRE_W{1'b0}}, 1'b1} << swt_shift(sel)) - CMP_W'(1);
    assign tick     = active && ({1'b0, pre} >= ratio_m1);

    // Divider count: clears when idle or on a tick, otherwise advances.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || tick) pre <= '0;
        else                           pre <= pre + PRE_W'(1);
    end

    // R2: with a steady select, the divider never runs past its terminal count
    a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $stable(sel)) |-> ({1'b0, pre} <= ratio_m1));

endmodule

// File: rtl/swt_nmi_edge.sv
// NMI edge detector: a two-flop synchronizer followed by a history flop.
// Gives a one-cycle hit on the edge chosen by rise_sel. Assumes nmi_in is
// asynchronous and held for at least two clock cycles per level.
module swt_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic rise_sel,
    output logic edge_hit
);
    logic s1, s2, s3;

    // Synchronize the line and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= nmi_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_hit = rise_sel ? (s2 && !s3) : (!s2 && s3);

    // R9: an edge hit lasts exactly one cycle
    a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> !edge_hit);

endmodule

// File: rtl/settle_wdt.sv
// Settling wait timer top. An up-counter, driven by the prescaler, serves
// two uses: a watchdog/interval timer (overflow -> reset or irq, flag set)
// and a clock-settling delay after a standby or frequency-change request
// (overflow -> clk_resume, flag untouched, counter parked at 0).
// Assumes a free-running clk, and that software clears enable before it
// issues a request.
module settle_wdt #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             standby_req,
    input  logic             freq_req,
    input  logic             nmi_in,
    input  logic             nmi_rise,
    output logic             clk_stop,
    output logic             clk_resume,
    output logic             wdt_reset,
    output logic             wdt_irq
);
    import swt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    swt_state_e       state;
    logic             en, rst_mode;
    logic [2:0]       sel;
    logic [CNT_W-1:0] cnt;
    logic             flag, flag_armed;
    logic             tick, edge_hit, active, ovf;
    logic             cnt_wr, ctrl_wr, stat_wr, in_settle, in_run;

    assign ctrl_wr   = bus_wr && (bus_addr == SWT_A_CTRL);
    assign cnt_wr    = bus_wr && (bus_addr == SWT_A_COUNT);
    assign stat_wr   = bus_wr && (bus_addr == SWT_A_STAT);
    assign in_settle = (state == SWT_SETTLE);
    assign in_run    = (state == SWT_RUN);
    assign active    = in_settle || (in_run && en);
    assign ovf       = tick && (cnt == CNT_MAX) && !cnt_wr;
    assign clk_stop  = !in_run;

    swt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .sel    (sel),
        .tick   (tick)
    );

    swt_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_in   (nmi_in),
        .rise_sel (nmi_rise),
        .edge_hit (edge_hit)
    );

    // Control register: enable, reset-mode, prescale select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            rst_mode <= 1'b0;
            sel      <= 3'd0;
        end else if (ctrl_wr) begin
            en       <= bus_wdata[7];
            rst_mode <= bus_wdata[6];
            sel      <= bus_wdata[2:0];
        end
    end

    // Mode sequencing: normal run, waiting for NMI, settling count.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SWT_RUN;
        else begin
            case (state)
                SWT_RUN: begin
                    if (freq_req)         state <= SWT_SETTLE;
                    else if (standby_req) state <= SWT_WAIT_EDGE;
                end
                SWT_WAIT_EDGE: if (edge_hit) state <= SWT_SETTLE;
                SWT_SETTLE:    if (ovf)      state <= SWT_RUN;
                default:                     state <= SWT_RUN;
            endcase
        end
    end

    // Counter: a software write wins; otherwise it advances on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= bus_wdata;
        else if (tick)   cnt <= cnt + CNT_W'(1);
    end

    // Overflow flag: a watchdog overflow sets it and beats a pending clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag       <= 1'b0;
            flag_armed <= 1'b0;
        end else if (in_run && ovf) begin
            flag       <= 1'b1;
            flag_armed <= 1'b0;
        end else if (stat_wr && !bus_wdata[0] && flag_armed) begin
            flag       <= 1'b0;
            flag_armed <= 1'b0;
        end else if (bus_rd && (bus_addr == SWT_A_STAT) && flag) begin
            flag_armed <= 1'b1;
        end
    end

    // Registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_resume <= 1'b0;
            wdt_reset  <= 1'b0;
            wdt_irq    <= 1'b0;
        end else begin
            clk_resume <= in_settle && ovf;
            wdt_reset  <= in_run && ovf && rst_mode;
            wdt_irq    <= in_run && ovf && !rst_mode;
        end
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            SWT_A_CTRL: begin
                bus_rdata[7]   = en;
                bus_rdata[6]   = rst_mode;
                bus_rdata[2:0] = sel;
            end
            SWT_A_COUNT: bus_rdata = cnt;
            SWT_A_STAT:  bus_rdata[0] = flag;
            default:     bus_rdata = '0;
        endcase
    end

    // R7: a settling overflow never raises the flag
    a_r7_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clk_resume |-> !$rose(flag));
    // R7: clock released when resume pulses
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        clk_resume |-> !clk_stop);
    // R8: counter parked at zero after a settling overflow
    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
        clk_resume |-> (cnt == '0));
    // R3: at most one event pulse at a time
    a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clk_resume, wdt_reset, wdt_irq}));
    // R11: any watchdog event comes with the flag set
    a_r11_flag_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq || wdt_reset) |-> flag);
    // R5: counter holds in run mode while disabled and not written
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_run) && !$past(en) && !$past(cnt_wr) && $past(rst_n)) |-> $stable(cnt));

endmodule

// File: tb/settle_wdt_bench.sv
module settle_wdt_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       standby_req = 1'b0, freq_req = 1'b0;
    logic       nmi_in = 1'b0, nmi_rise = 1'b1;
    logic       clk_stop, clk_resume, wdt_reset, wdt_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    settle_wdt u_settle_wdt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .standby_req(standby_req), .freq_req(freq_req), .nmi_in(nmi_in),
        .nmi_rise(nmi_rise), .clk_stop(clk_stop), .clk_resume(clk_resume),
        .wdt_reset(wdt_reset), .wdt_irq(wdt_irq)
    );

    function automatic int ratio_of(input int sel);
        case (sel)
            0: return 1;    1: return 4;    2: return 16;   3: return 32;
            4: return 64;   5: return 256;  6: return 1024; default: return 4096;
        endcase
    endfunction

    function automatic int edges_to_ovf(input int start, input int sel);
        return (256 - start) * ratio_of(sel);
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr[1:0]; bus_wdata = data[7:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = addr[1:0];
        #1 data = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Counts edges until the chosen pulse is seen (0 resume, 1 irq, 2 reset).
    task automatic wait_evt(input int which, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            if ((which == 0 && clk_resume) || (which == 1 && wdt_irq) ||
                (which == 2 && wdt_reset)) break;
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got %0h expected %0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, n, start, sel, mode;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 count", v, 0);
        rd(2, v); chk("R1 flag", v, 0);
        chk("R1 outputs", {clk_stop, clk_resume, wdt_reset, wdt_irq}, 0);

        // R1 reset while waiting in standby
        wr(1, 8'hF8);
        @(negedge clk) standby_req = 1'b1;
        @(negedge clk) standby_req = 1'b0;
        chk("R9 standby stops clock", clk_stop, 1);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R1 reset leaves standby", clk_stop, 0);
        nmi_in = 1'b1;
        repeat (20) @(negedge clk);
        rd(1, v); chk("R1 no count after reset-exit", v, 0);
        nmi_in = 1'b0;
        repeat (4) @(negedge clk);

        // R5 disabled counter holds
        wr(1, 8'h55);
        repeat (30) @(negedge clk);
        rd(1, v); chk("R5 hold", v, 8'h55);

        // R2 every prescale ratio, measured through interval overflow
        for (int s = 0; s < 8; s++) begin
            wr(1, 8'hFF);
            wr(0, 8'h80 | s);
            wait_evt(1, 10000, n);
            chk($sformatf("R2 ratio sel=%0d", s), n, edges_to_ovf(8'hFF, s));
            wr(0, 0);
        end

        // R3 interval overflow: pulse, flag, wrap
        wr(1, 8'hF0);
        wr(0, 8'h80);
        wait_evt(1, 1000, n);
        chk("R3 irq timing", n, 16);
        chk("R3 irq not reset", wdt_reset, 0);
        bus_addr = 2'd1; #1 chk("R3 wrap to zero", bus_rdata, 0);
        @(negedge clk) chk("R3 irq one cycle", wdt_irq, 0);
        wr(0, 0);
        rd(2, v); chk("R3 flag set", v, 1);

        // R10 write 0 without read keeps flag (flag was read just above: re-trigger first)
        wr(1, 8'hFE); wr(0, 8'h80); wait_evt(1, 100, n); wr(0, 0);
        wr(2, 0);
        bus_addr = 2'd2; #1 chk("R10 no-read clear ignored", bus_rdata, 1);
        rd(2, v);
        wr(2, 0);
        bus_addr = 2'd2; #1 chk("R10 read then clear", bus_rdata, 0);

        // R4 reset mode
        wr(1, 8'hF8);
        wr(0, 8'hC0);
        wait_evt(2, 1000, n);
        chk("R4 reset timing", n, 8);
        chk("R4 no irq", wdt_irq, 0);
        wr(0, 0);
        rd(2, v); chk("R4 flag set", v, 1);

        // R11 overflow and armed clear on the same edge
        wr(1, 8'hF0);
        wr(0, 8'h80);
        repeat (15) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R11 irq on collision edge", wdt_irq, 1);
        #1 chk("R11 flag kept", bus_rdata, 1);

        // R12 count write beats tick (counter still running with ratio 1)
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h10;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 chk("R12 write priority", bus_rdata, 8'h10);
        wr(0, 0);

        // R6 R7 R8 frequency-change settling, random start and ratio
        for (int t = 0; t < 12; t++) begin
            start = 8'hC0 + ($urandom % 64);
            sel = $urandom % 3;
            wr(0, sel);
            wr(1, start);
            rd(2, v); mode = v;
            @(negedge clk) freq_req = 1'b1;
            @(negedge clk) freq_req = 1'b0;
            chk("R6 clock stopped", clk_stop, 1);
            wait_evt(0, 20000, n);
            chk("R6 settle timing", n, edges_to_ovf(start, sel));
            chk("R7 clock released", clk_stop, 0);
            chk("R7 no watchdog event", {wdt_irq, wdt_reset}, 0);
            bus_addr = 2'd2; #1 chk("R7 flag untouched", bus_rdata, mode);
            repeat (40) @(negedge clk);
            rd(1, v); chk("R8 parked", v, 0);
        end
        wr(1, 8'h33);
        rd(1, v); chk("R8 software write after park", v, 8'h33);

        // R9 standby: wrong polarity ignored, then falling edge starts count
        nmi_rise = 1'b0;
        wr(0, 0);
        wr(1, 8'hF0);
        @(negedge clk) standby_req = 1'b1;
        @(negedge clk) standby_req = 1'b0;
        nmi_in = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 still stopped", clk_stop, 1);
        rd(1, v); chk("R9 wrong edge ignored", v, 8'hF0);
        @(negedge clk) nmi_in = 1'b0;
        wait_evt(0, 1000, n);
        chk("R9 edge latency", n, 3 + 16);
        chk("R9 released", clk_stop, 0);
        nmi_rise = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule